// File: doc/BRIEF.md
# Forced-caching instruction line filler

This block sits between an instruction-fetch front end and a memory read port whose bus is 16 bytes wide. It takes one miss request at a time and chooses how to serve it. A cacheable miss, of either type, is served as an ordinary 64-byte line fill. A noncacheable operand miss is always served uncached with a single 16-byte read. A noncacheable instruction miss is served uncached when the force-cache mode bit is clear. When the bit is set, the block instead reads the whole enclosing line in four ascending beats and delivers it to the instruction cache on the fill port, as if it were cacheable.

The request input and both memory channels use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. A source that raises valid keeps it high, and keeps its payload stable, until the transfer. The block takes no new miss while a sequence is in flight. The fill port, the uncached return and the done pulse have no back-pressure. The mode bit and the flush-complete input are plain levels and pulses. An error pulse flags a clear of the mode bit made without an instruction-cache flush having completed since the bit was set.

Top module: `nc_line_filler`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, and fill_valid, pass_valid, done, clr_err and mem_req_valid are 0.
- R2: A noncacheable instruction miss accepted with force_cache=1 produces exactly four memory reads at line_base+0, +16, +32 and +48, in that order, where line_base is req_addr with bits [5:0] cleared. It ends in a line fill and not in an uncached return.
- R3: fill_valid is high for exactly one cycle: the cycle after the fourth response is accepted. In that cycle fill_addr equals line_base, and fill_data bits [128k+127:128k] hold the response to the read at line_base+16k, for k=0..3.
- R4: A noncacheable instruction miss accepted with force_cache=0 produces one read at req_addr with bits [3:0] cleared. In the cycle after its response is accepted, pass_valid is 1 and pass_data equals that response. fill_valid stays 0.
- R5: A noncacheable operand miss (req_is_instr=0) is served as in R4 whatever the value of force_cache.
- R6: A cacheable miss (req_cacheable=1) of either type is served as the line fill of R2 and R3, whatever the value of force_cache.
- R7: req_ready is 0 from the cycle after a request is accepted until the cycle of done. done is high for one cycle, in the same cycle as fill_valid or pass_valid. req_ready is 1 again in that cycle.
- R8: force_cache is sampled in the cycle the request is accepted. Changing it later does not alter the running sequence.
- R9: While mem_req_valid is high and mem_req_ready is low, mem_req_valid stays high and mem_req_addr stays stable. Each beat is requested once, and responses are taken only while mem_rsp_ready is high, so stalls on either channel do not change the beats or the data.
- R10: clr_err pulses for one cycle, in the cycle after force_cache is first seen low following a high period, when no flush_done pulse has arrived since the bit went high. A flush_done pulse in the same cycle as the clear counts as a completed flush. The clear takes effect either way.
- R11: A flush_done pulse in the same cycle that force_cache goes high does not count as a flush for the following clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| force_cache | input | 1 | Mode bit: cache noncacheable instruction lines |
| flush_done | input | 1 | One-cycle pulse: an instruction-cache flush has completed |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Block can accept a miss request |
| req_addr | input | 32 | Miss byte address |
| req_cacheable | input | 1 | 1 = region is cacheable |
| req_is_instr | input | 1 | 1 = instruction fetch, 0 = operand access |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | 16-byte-aligned read address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_ready | output | 1 | Block accepts read data |
| mem_rsp_data | input | 128 | One 16-byte beat of read data |
| fill_valid | output | 1 | One-cycle line fill strobe to the instruction cache |
| fill_addr | output | 32 | Line base address of the fill |
| fill_data | output | 512 | Full line, lowest beat in the low bits |
| pass_valid | output | 1 | One-cycle uncached return strobe |
| pass_data | output | 128 | Uncached 16-byte beat |
| done | output | 1 | One-cycle pulse: the request is finished |
| clr_err | output | 1 | One-cycle pulse: mode bit cleared without a prior flush |

## Verification
The flush-complete pulse and the clearing of the mode bit can fall in the same cycle, and so can the flush pulse and the setting of the bit. The bench drives each pair on one clock edge, and also the same events a cycle apart. A flush that coincides with the clear must suppress the error pulse. A flush that coincides with the set must not, so a later clear still pulses clr_err. The bench checks this one cycle after the clear edge, and checks that the pulse is gone on the following cycle.

// File: rtl/ncf_pkg.sv
package ncf_pkg;
  typedef enum logic {
    XFER_PASS = 1'b0,
    XFER_LINE = 1'b1
  } xfer_e;
endpackage

// File: rtl/ncf_classify.sv
module ncf_classify
  import ncf_pkg::*;
(
  input  logic  cacheable,
  input  logic  is_instr,
  input  logic  force_cache,
  output xfer_e kind
);
  always_comb begin
    if (cacheable) begin
      kind = XFER_LINE;
    end else if (is_instr && force_cache) begin
      kind = XFER_LINE;
    end else begin
      kind = XFER_PASS;
    end
  end
endmodule

// File: rtl/ncf_beat_issue.sv
module ncf_beat_issue
  import ncf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_e             kind,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr
);
  localparam int BEATS  = LINE_BYTES / BEAT_BYTES;
  localparam int BOFF_W = $clog2(BEAT_BYTES);
  localparam int LOFF_W = $clog2(LINE_BYTES);
  localparam int CNT_W  = $clog2(BEATS) + 1;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  sent_q;
  logic [CNT_W-1:0]  limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      sent_q  <= '0;
      limit_q <= '0;
    end else if (start) begin
      sent_q <= '0;
      if (kind == XFER_LINE) begin
        base_q  <= {addr[ADDR_W-1:LOFF_W], {LOFF_W{1'b0}}};
        limit_q <= CNT_W'(BEATS);
      end else begin
        base_q  <= {addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
        limit_q <= CNT_W'(1);
      end
    end else if (mem_req_valid && mem_req_ready) begin
      sent_q <= sent_q + CNT_W'(1);
    end
  end

  assign mem_req_valid = (sent_q < limit_q);
  assign mem_req_addr  = base_q + (ADDR_W'(sent_q) << BOFF_W);
endmodule

// File: rtl/ncf_line_gather.sv
module ncf_line_gather
  import ncf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  xfer_e                     kind,
  input  logic [ADDR_W-1:0]         line_addr,
  input  logic                      rsp_valid,
  input  logic [BEAT_BYTES*8-1:0]   rsp_data,
  output logic                      rsp_ready,
  output logic                      busy,
  output logic                      fill_valid,
  output logic                      pass_valid,
  output logic                      done,
  output logic [ADDR_W-1:0]         fill_addr,
  output logic [LINE_BYTES*8-1:0]   fill_data,
  output logic [BEAT_BYTES*8-1:0]   pass_data
);
  localparam int BEATS  = LINE_BYTES / BEAT_BYTES;
  localparam int BEAT_W = BEAT_BYTES * 8;
  localparam int CNT_W  = $clog2(BEATS) + 1;

  xfer_e             kind_q;
  logic [CNT_W-1:0]  need_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic [ADDR_W-1:0] line_q;
  logic              accept;
  logic              last;
  logic [BEAT_W-1:0] slot_q [BEATS];

  assign accept = rsp_valid && busy_q;
  assign last   = accept && (cnt_q == need_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q     <= XFER_PASS;
      need_q     <= '0;
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      line_q     <= '0;
      fill_valid <= 1'b0;
      pass_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      fill_valid <= 1'b0;
      pass_valid <= 1'b0;
      done       <= 1'b0;
      if (start) begin
        kind_q <= kind;
        need_q <= (kind == XFER_LINE) ? CNT_W'(BEATS) : CNT_W'(1);
        cnt_q  <= '0;
        busy_q <= 1'b1;
        line_q <= line_addr;
      end else if (last) begin
        busy_q     <= 1'b0;
        done       <= 1'b1;
        fill_valid <= (kind_q == XFER_LINE);
        pass_valid <= (kind_q == XFER_PASS);
      end else if (accept) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (accept && (cnt_q == CNT_W'(g))) begin
        slot_q[g] <= rsp_data;
      end
    end
    assign fill_data[g*BEAT_W +: BEAT_W] = slot_q[g];
  end

  assign rsp_ready = busy_q;
  assign busy      = busy_q;
  assign fill_addr = line_q;
  assign pass_data = slot_q[0];
endmodule

// File: rtl/ncf_flush_guard.sv
module ncf_flush_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic force_cache,
  input  logic flush_done,
  output logic clr_err
);
  logic force_q;
  logic flushed_q;
  logic rise;
  logic fall;

  assign rise = force_cache && !force_q;
  assign fall = !force_cache && force_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_q   <= 1'b0;
      flushed_q <= 1'b1;
      clr_err   <= 1'b0;
    end else begin
      force_q <= force_cache;
      if (rise) begin
        flushed_q <= 1'b0;
      end else if (flush_done) begin
        flushed_q <= 1'b1;
      end
      clr_err <= fall && !(flushed_q || flush_done);
    end
  end
endmodule

// File: rtl/nc_line_filler.sv
module nc_line_filler
  import ncf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 16,
  parameter int LINE_BYTES = 64,
  localparam int BEAT_W    = BEAT_BYTES * 8,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_cache,
  input  logic              flush_done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cacheable,
  input  logic              req_is_instr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [BEAT_W-1:0] mem_rsp_data,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [LINE_W-1:0] fill_data,
  output logic              pass_valid,
  output logic [BEAT_W-1:0] pass_data,
  output logic              done,
  output logic              clr_err
);
  localparam int LOFF_W = $clog2(LINE_BYTES);

  xfer_e             kind;
  logic              start;
  logic              busy;
  logic [ADDR_W-1:0] line_base;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;
  assign line_base = {req_addr[ADDR_W-1:LOFF_W], {LOFF_W{1'b0}}};

  ncf_classify u_classify (
    .cacheable   (req_cacheable),
    .is_instr    (req_is_instr),
    .force_cache (force_cache),
    .kind        (kind)
  );

  ncf_beat_issue #(
    .ADDR_W     (ADDR_W),
    .BEAT_BYTES (BEAT_BYTES),
    .LINE_BYTES (LINE_BYTES)
  ) u_issue (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .kind          (kind),
    .addr          (req_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
  );

  ncf_line_gather #(
    .ADDR_W     (ADDR_W),
    .BEAT_BYTES (BEAT_BYTES),
    .LINE_BYTES (LINE_BYTES)
  ) u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .kind       (kind),
    .line_addr  (line_base),
    .rsp_valid  (mem_rsp_valid),
    .rsp_data   (mem_rsp_data),
    .rsp_ready  (mem_rsp_ready),
    .busy       (busy),
    .fill_valid (fill_valid),
    .pass_valid (pass_valid),
    .done       (done),
    .fill_addr  (fill_addr),
    .fill_data  (fill_data),
    .pass_data  (pass_data)
  );

  ncf_flush_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_cache (force_cache),
    .flush_done  (flush_done),
    .clr_err     (clr_err)
  );
endmodule

// File: rtl/nc_line_filler_chk.sv
module nc_line_filler_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              force_cache,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              fill_valid,
  input logic              pass_valid,
  input logic              done,
  input logic              clr_err
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

  AST_BEAT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[3:0] == 4'h0)); // R2

  AST_FILL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid); // R3

  AST_FILL_PASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && pass_valid)); // R4

  AST_DONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((fill_valid || pass_valid) && req_ready)); // R7

  AST_RESULT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || pass_valid) |-> done); // R7

  AST_ERR_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |-> ($past(!force_cache) && $past(force_cache, 2))); // R10

  AST_ERR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !clr_err); // R10
endmodule

bind nc_line_filler nc_line_filler_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .force_cache   (force_cache),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .fill_valid    (fill_valid),
  .pass_valid    (pass_valid),
  .done          (done),
  .clr_err       (clr_err)
);

// File: tb/nc_line_filler_test.sv
`timescale 1ns/1ps
module nc_line_filler_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         force_cache = 1'b0;
  logic         flush_done = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic         req_cacheable = 1'b0;
  logic         req_is_instr = 1'b0;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic         mem_rsp_ready;
  logic [127:0] mem_rsp_data = '0;
  logic         fill_valid;
  logic [31:0]  fill_addr;
  logic [511:0] fill_data;
  logic         pass_valid;
  logic [127:0] pass_data;
  logic         done;
  logic         clr_err;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  nc_line_filler uut (
    .clk(clk), .rst_n(rst_n), .force_cache(force_cache), .flush_done(flush_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cacheable(req_cacheable), .req_is_instr(req_is_instr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .pass_valid(pass_valid), .pass_data(pass_data), .done(done), .clr_err(clr_err)
  );

  typedef struct packed {
    logic        cach;
    logic        instr;
    logic        frc;
    logic        flip;
    logic [31:0] addr;
    logic        exp_line;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_1234, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_2A5C, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_30F8, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_4007, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_5FFF, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_6040, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1, 32'h0007_0010, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b1, 32'h0008_0021, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFF0, 1'b1}
  };

  // memory model state
  logic [31:0] q_addr [8];
  logic [31:0] log_addr [8];
  int wr = 0;
  int rd = 0;
  int nlog = 0;
  int cyc = 0;
  bit p_req = 0;
  bit p_rsp = 0;
  logic [31:0] p_addr = '0;

  function automatic logic [127:0] beat_of(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a, a + 32'd7, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (p_req && nlog < 8 && wr < 8) begin
      log_addr[nlog] = p_addr;
      nlog++;
      q_addr[wr] = p_addr;
      wr++;
    end
    if (p_rsp) rd++;
    cyc++;
    mem_req_ready = (cyc % 3) != 1;
    mem_rsp_valid = (rd < wr) && ((cyc % 4) != 2);
    mem_rsp_data  = (rd < wr) ? beat_of(q_addr[rd]) : '0;
    p_req  = mem_req_valid && mem_req_ready;
    p_addr = mem_req_addr;
    p_rsp  = mem_rsp_valid && mem_rsp_ready;
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    int exp_beats;
    int n;
    int ready_busy;
    logic [31:0] base;
    logic [511:0] exp_line_data;
    if (v.flip) tag = "R8";
    else if (v.cach) tag = "R6";
    else if (!v.instr) tag = "R5";
    else if (v.frc) tag = "R2";
    else tag = "R4";
    exp_beats = v.exp_line ? 4 : 1;
    base = v.exp_line ? {v.addr[31:6], 6'h0} : {v.addr[31:4], 4'h0};
    force_cache = v.frc;
    tick();
    wr = 0; rd = 0; nlog = 0;
    chk(req_ready == 1'b1, "R7", "ready when idle", 512'(req_ready), 512'(1));
    req_valid = 1'b1;
    req_addr = v.addr;
    req_cacheable = v.cach;
    req_is_instr = v.instr;
    tick();
    req_valid = 1'b0;
    if (v.flip) force_cache = ~force_cache;
    n = 0;
    ready_busy = 0;
    while (rd < exp_beats && n < 200) begin
      if (req_ready) ready_busy++;
      tick();
      n++;
    end
    chk(ready_busy == 0, "R7", "ready while busy", 512'(ready_busy), 512'(0));
    chk(done == 1'b1, "R7", "done after last beat", 512'(done), 512'(1));
    chk(fill_valid == v.exp_line, tag, "fill_valid", 512'(fill_valid), 512'(v.exp_line));
    chk(pass_valid == !v.exp_line, tag, "pass_valid", 512'(pass_valid), 512'(!v.exp_line));
    chk(nlog == exp_beats, "R9", "beat count", 512'(nlog), 512'(exp_beats));
    for (int k = 0; k < exp_beats; k++) begin
      chk(log_addr[k] == base + 32'(16 * k), tag, "beat address",
          512'(log_addr[k]), 512'(base + 32'(16 * k)));
    end
    if (v.exp_line) begin
      for (int k = 0; k < 4; k++) exp_line_data[k*128 +: 128] = beat_of(base + 32'(16 * k));
      chk(fill_data == exp_line_data, "R3", "fill_data", fill_data, exp_line_data);
      chk(fill_addr == base, "R3", "fill_addr", 512'(fill_addr), 512'(base));
    end else begin
      chk(pass_data == beat_of(base), tag, "pass_data", 512'(pass_data), 512'(beat_of(base)));
    end
    tick();
    chk(fill_valid == 1'b0 && done == 1'b0, "R3", "strobes one cycle",
        512'({fill_valid, done}), 512'(0));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(req_ready && !fill_valid && !pass_valid && !done && !clr_err && !mem_req_valid,
        "R1", "outputs in reset",
        512'({req_ready, fill_valid, pass_valid, done, clr_err, mem_req_valid}), 512'(6'b100000));
    rst_n = 1'b1;
    tick();
    chk(req_ready && !fill_valid && !pass_valid && !done && !clr_err && !mem_req_valid,
        "R1", "outputs after reset",
        512'({req_ready, fill_valid, pass_valid, done, clr_err, mem_req_valid}), 512'(6'b100000));

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R10: clear without flush raises the error
    force_cache = 1'b0; tick(); tick();
    force_cache = 1'b1; tick(); tick();
    force_cache = 1'b0; tick();
    chk(clr_err == 1'b1, "R10", "clear without flush", 512'(clr_err), 512'(1));
    tick();
    chk(clr_err == 1'b0, "R10", "error is one cycle", 512'(clr_err), 512'(0));

    // R10: flush between set and clear
    force_cache = 1'b1; tick();
    flush_done = 1'b1; tick();
    flush_done = 1'b0; tick();
    force_cache = 1'b0; tick();
    chk(clr_err == 1'b0, "R10", "clear after flush", 512'(clr_err), 512'(0));

    // R10: flush in the same cycle as the clear
    force_cache = 1'b1; tick(); tick();
    force_cache = 1'b0; flush_done = 1'b1; tick();
    flush_done = 1'b0;
    chk(clr_err == 1'b0, "R10", "flush with clear", 512'(clr_err), 512'(0));
    tick();
    chk(clr_err == 1'b0, "R10", "no late error", 512'(clr_err), 512'(0));

    // R11: flush in the same cycle as the set does not count
    force_cache = 1'b1; flush_done = 1'b1; tick();
    flush_done = 1'b0; tick();
    force_cache = 1'b0; tick();
    chk(clr_err == 1'b1, "R11", "flush with set ignored", 512'(clr_err), 512'(1));

    // R10: the clear took effect, noncacheable fetch is passed uncached
    run_vec('{1'b0, 1'b1, 1'b0, 1'b0, 32'h0009_0038, 1'b0});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule